// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Overflow Flags

This block is a 16-bit up-counter, made of a low byte and a high byte, that software can read but never load. Its count pulses pass through a prescaler that divides by 1, 2, 4 or 8. The prescaler takes its input from one of three sources: nothing at all, an internal machine-cycle tick, or rising edges on an external count pin. A second pin, when enabled, clears the counter and the prescaler on its rising edge.

Timing comes from `halfTick`, a strobe that pulses twice per machine cycle. The first pulse of each pair is the first sample point of a machine cycle and the second pulse is the second sample point. Both external pins are sampled on every `halfTick`. A rising edge is seen when one sample is low and the next is high. Internal counting happens on first sample points.

Two sticky flags record overflow events: one for the low byte wrapping and one for the full 16-bit counter wrapping. A single interrupt line combines them under two select bits and a global enable. A small register bus carries the control bits, write-one-to-clear access to the flags, and reads of both counter bytes.

Top module: `prescaled_timer`

## Requirements
- R1: After the synchronous reset `rst`, all of the following read as zero: the control register, both flags, both counter bytes and `irq`. Both pin samples start high, so a pin that is already high at reset is not taken as an edge.
- R2: When control bits [1:0] hold 00 or 11, the source is off and the counter does not count. Only an external reset can change it.
- R3: Control bits [1:0] = 01 selects the internal source, which delivers one prescaler pulse on each first sample point. Control bits [3:2] = k make the counter step once every 2^k prescaler pulses.
- R4: Control bits [1:0] = 10 selects the external count pin. A rising edge found at a first sample point gives a prescaler pulse at the next machine cycle's first sample point. A rising edge found at a second sample point gives its pulse one machine cycle later than that. There is at most one pulse per machine cycle.
- R5: A control write that changes bits [3:0] clears the prescaler and discards that cycle's prescaler pulse. A write that leaves bits [3:0] unchanged leaves the prescaler running.
- R6: Flag bit 0 is the byte flag and bit 1 is the word flag. When the low byte wraps from FF to 00, the byte flag sets one clock after the counter changes. When the whole counter wraps from FFFF, both flags set in that same later clock.
- R7: `irq` = ctrl[7] AND ((ctrl[5] AND byte flag) OR (ctrl[6] AND word flag)).
- R8: Writing a 1 to address 1 bit 0 clears the byte flag, and writing a 1 to bit 1 clears the word flag. Each flag clears independently of the other. Nothing else clears a flag. If a clear arrives in the same clock that a flag is being set, the flag stays set.
- R9: When ctrl[4] is 1, a rising edge on `rstPin` clears the counter and the prescaler in the same clock that the edge is sampled. It wins over an increment in that clock. The edge is found by the same two-sample method used for the count pin. When ctrl[4] is 0, the pin has no effect.
- R10: Reads: address 0 returns the control register, 1 returns the flags, 2 returns the counter low byte and 3 returns the counter high byte. All reads are live, with no latching. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| halfTick | input | 1 | Sample strobe, two pulses per machine cycle |
| cntPin | input | 1 | External count input |
| rstPin | input | 1 | External counter reset input |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The internal source is run at each of the four division ratios, and the ratio is changed both mid-count and to an identical value. This separates a correct divider from one that never clears and from one that clears on every write. The external pin is driven with pulses of varying width, so that edges land at both sample points and also come closer together than one machine cycle; these patterns expose wrong edge timing and double counting. Reset-pin pulses are sent with the enable bit set and with it clear. A long run at full strobe rate reaches both wraps, while repeated flag clears collide with flag sets to expose any wrong priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SRC_OFF = 2'd0;
  localparam logic [1:0] SRC_INT = 2'd1;
  localparam logic [1:0] SRC_EXT = 2'd2;

  localparam int CB_RSTEN = 4;
  localparam int CB_BSEL  = 5;
  localparam int CB_WSEL  = 6;
  localparam int CB_GEN   = 7;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_LOW  = 2'd2;
  localparam logic [1:0] A_HIGH = 2'd3;

  typedef struct packed {
    logic inc;
    logic zero;
    logic clrByte;
    logic clrWord;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halfTick,
  input  logic              cntPin,
  input  logic              rstPin,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] ctrlReg,
  output tmrStrobe_t        strobe
);
  localparam int SPAN_W = PRE_W + 1;

  logic             phase;
  logic             sampC, sampR;
  logic             stLate, stNext;
  logic [PRE_W-1:0] preCnt;

  logic firstPt, edgeC, edgeR, rstHit, ctrlWr, cfgChg, srcTick, wrap, preClr;
  logic [SPAN_W-1:0] span;
  logic [PRE_W-1:0]  preLast;

  always_comb begin
    firstPt = halfTick & ~phase;
    edgeC   = halfTick & ~sampC & cntPin;
    edgeR   = halfTick & ~sampR & rstPin;
    rstHit  = edgeR & ctrlReg[CB_RSTEN];
    ctrlWr  = wrEn & (addr == A_CTRL);
    cfgChg  = ctrlWr & (wrData[3:0] != ctrlReg[3:0]);
    srcTick = firstPt & ((ctrlReg[1:0] == SRC_INT) |
                         ((ctrlReg[1:0] == SRC_EXT) & stNext));
    span    = SPAN_W'(1) << ctrlReg[3:2];
    preLast = PRE_W'(span - SPAN_W'(1));
    wrap    = srcTick & (preCnt == preLast);
    preClr  = rstHit | cfgChg;

    strobe.inc     = wrap & ~preClr;
    strobe.zero    = rstHit;
    strobe.clrByte = wrEn & (addr == A_FLAG) & wrData[0];
    strobe.clrWord = wrEn & (addr == A_FLAG) & wrData[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      sampC   <= 1'b1;
      sampR   <= 1'b1;
      stLate  <= 1'b0;
      stNext  <= 1'b0;
      preCnt  <= '0;
      ctrlReg <= '0;
    end else begin
      if (halfTick) begin
        phase <= ~phase;
        sampC <= cntPin;
        sampR <= rstPin;
        if (firstPt) begin
          stNext <= edgeC | stLate;
          stLate <= 1'b0;
        end else if (edgeC) begin
          stLate <= 1'b1;
        end
      end
      if (preClr)       preCnt <= '0;
      else if (wrap)    preCnt <= '0;
      else if (srcTick) preCnt <= preCnt + PRE_W'(1);
      if (ctrlWr) ctrlReg <= wrData;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  tmrStrobe_t          strobe,
  output logic [2*BYTE_W-1:0] cntVal,
  output logic                byteFlag,
  output logic                wordFlag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic byteOvP, wordOvP, step;

  assign step = strobe.inc & ~strobe.zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal   <= '0;
      byteOvP  <= 1'b0;
      wordOvP  <= 1'b0;
      byteFlag <= 1'b0;
      wordFlag <= 1'b0;
    end else begin
      if (strobe.zero)  cntVal <= '0;
      else if (step)    cntVal <= cntVal + CNT_W'(1);
      byteOvP  <= step & (cntVal[BYTE_W-1:0] == '1);
      wordOvP  <= step & (cntVal == '1);
      byteFlag <= byteOvP | (byteFlag & ~strobe.clrByte);
      wordFlag <= wordOvP | (wordFlag & ~strobe.clrWord);
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halfTick,
  input  logic              cntPin,
  input  logic              rstPin,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  tmrStrobe_t        strobe;
  logic [BYTE_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  cntVal;
  logic              byteFlag, wordFlag;

  tmr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .halfTick(halfTick), .cntPin(cntPin), .rstPin(rstPin),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .ctrlReg(ctrlReg), .strobe(strobe)
  );

  tmr_count #(.BYTE_W(BYTE_W)) u_count (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cntVal(cntVal), .byteFlag(byteFlag), .wordFlag(wordFlag)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:  rdData = ctrlReg;
      A_FLAG:  rdData = {{(BYTE_W-2){1'b0}}, wordFlag, byteFlag};
      A_LOW:   rdData = cntVal[BYTE_W-1:0];
      default: rdData = cntVal[CNT_W-1:BYTE_W];
    endcase
    irq = ctrlReg[CB_GEN] & ((ctrlReg[CB_BSEL] & byteFlag) |
                             (ctrlReg[CB_WSEL] & wordFlag));
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wrEn,
  input logic [1:0]          addr,
  input logic [BYTE_W-1:0]   wrData,
  input logic [BYTE_W-1:0]   ctrlReg,
  input logic [2*BYTE_W-1:0] cntVal,
  input logic                byteFlag,
  input logic                wordFlag,
  input logic                irq
);
  // R2: an off source leaves the counter alone except for a clear
  a_r2_off_holds: assert property (@(posedge clk) disable iff (rst)
    (ctrlReg[1:0] == 2'd0 || ctrlReg[1:0] == 2'd3) |=> ($stable(cntVal) || cntVal == '0));

  // R6: a word-flag set always brings the byte flag with it
  a_r6_word_sets_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(wordFlag) |-> byteFlag);

  // R7: interrupt gating
  a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
    !ctrlReg[7] |-> !irq);
  a_r7_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (byteFlag || wordFlag));

  // R8: flags only fall on a software clear
  a_r8_byte_sw_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(byteFlag) |-> $past(wrEn && addr == 2'd1 && wrData[0]));
  a_r8_word_sw_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(wordFlag) |-> $past(wrEn && addr == 2'd1 && wrData[1]));

  // R10: no load path, the counter only steps by one or clears
  a_r10_no_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(cntVal) |-> (cntVal == $past(cntVal) + 1'b1 || cntVal == '0));
endmodule

bind prescaled_timer tmr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctrlReg(ctrlReg), .cntVal(cntVal), .byteFlag(byteFlag),
  .wordFlag(wordFlag), .irq(irq)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halfTick = 1'b0;
  logic       cntPin = 1'b0;
  logic       rstPin = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    fastTick = 0;
  int    tickCnt = 0;
  bit    done = 0;

  // reference model state
  bit mPhase, mSampC, mSampR, mLate, mNext, mBOv, mWOv, mFB, mFW;
  int mPre, mCnt, mCtrl;

  always #5 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst(rst), .halfTick(halfTick), .cntPin(cntPin), .rstPin(rstPin),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int modelRd(int a);
    case (a)
      0: return mCtrl;
      1: return (int'(mFW) << 1) | int'(mFB);
      2: return mCnt % 256;
      default: return mCnt / 256;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mSampC = 1; mSampR = 1; mLate = 0; mNext = 0;
      mPre = 0; mCnt = 0; mBOv = 0; mWOv = 0; mFB = 0; mFW = 0; mCtrl = 0;
    end else begin
      int src, dv, preN;
      bit first, eC, eR, hit, cfg, st, inc, bN, wN;
      src   = mCtrl % 4;
      dv    = (mCtrl / 4) % 4;
      first = halfTick && !mPhase;
      eC    = halfTick && !mSampC && cntPin;
      eR    = halfTick && !mSampR && rstPin;
      hit   = eR && mCtrl[4];
      cfg   = wrEn && addr == 0 && (wrData % 16) != (mCtrl % 16);
      st    = first && (src == 1 || (src == 2 && mNext));
      inc   = 0;
      preN  = mPre;
      if (hit || cfg) preN = 0;
      else if (st) begin
        if (mPre == (1 << dv) - 1) begin inc = 1; preN = 0; end
        else preN = mPre + 1;
      end
      bN = inc && !hit && (mCnt % 256 == 255);
      wN = inc && !hit && (mCnt == 65535);
      mFB = mBOv || (mFB && !(wrEn && addr == 1 && wrData[0]));
      mFW = mWOv || (mFW && !(wrEn && addr == 1 && wrData[1]));
      mBOv = bN; mWOv = wN;
      if (hit) mCnt = 0;
      else if (inc) mCnt = (mCnt + 1) % 65536;
      mPre = preN;
      if (halfTick) begin
        if (first) begin mNext = eC || mLate; mLate = 0; end
        else if (eC) mLate = 1;
        mSampC = cntPin; mSampR = rstPin; mPhase = !mPhase;
      end
      if (wrEn && addr == 0) mCtrl = wrData;
    end
  end

  // compare every clock, then drive the strobe
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(curReq, rdData, modelRd(addr));
      chk("R7", irq, mCtrl[7] && ((mCtrl[5] && mFB) || (mCtrl[6] && mFW)));
    end
    tickCnt++;
    halfTick <= fastTick ? 1'b1 : tickCnt[0];
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic [1:0] back);
    wrEn = 1; addr = a; wrData = d;
    step(1);
    wrEn = 0; addr = back;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a; #1; v = rdData;
  endtask

  initial begin
    int v;
    step(4);
    rst = 0;
    step(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1", v, 0); end
    chk("R1", irq, 0);

    // R2: source off, pins moving, reset pin disabled
    curReq = "R2"; addr = 2;
    for (int i = 0; i < 40; i++) begin cntPin = i[1]; rstPin = i[2]; step(1); end
    rd(2, v); chk("R2", v, 0);
    wr(0, 8'h03, 2);
    for (int i = 0; i < 30; i++) begin cntPin = i[1]; step(1); end
    rd(2, v); chk("R2", v, 0);
    cntPin = 0; rstPin = 0;

    // R3: internal source at each division
    curReq = "R3";
    wr(0, 8'h01, 2); step(60);
    wr(0, 8'h05, 2); step(80);
    wr(0, 8'h09, 3); step(120);
    wr(0, 8'h0D, 2); step(250);

    // R5: same-value write keeps prescaler, changed value clears it
    curReq = "R5";
    step(9); wr(0, 8'h0D, 2); step(21);
    wr(0, 8'h09, 2); step(13);
    wr(0, 8'h0D, 2); step(7); wr(0, 8'h01, 2); step(40);

    // R4: external edges of varied spacing
    curReq = "R4";
    wr(0, 8'h02, 2);
    for (int i = 0; i < 120; i++) begin
      cntPin = ~cntPin;
      step(1 + ((i * 7) % 5));
      if (i == 60) addr = 3;
    end
    cntPin = 0; addr = 2; step(20);

    // R9: external reset enabled and disabled
    curReq = "R9";
    wr(0, 8'h11, 2);
    for (int i = 0; i < 8; i++) begin
      step(30 + i); rstPin = 1; step(1 + i % 3); rstPin = 0;
    end
    step(20);
    rd(2, v);
    wr(0, 8'h01, 2);
    for (int i = 0; i < 5; i++) begin step(25); rstPin = 1; step(3); rstPin = 0; end
    step(10);

    // R10: writes to the counter bytes have no effect
    curReq = "R10";
    wr(2, 8'h55, 2); wr(3, 8'hAA, 3); step(10);
    wr(2, 8'h00, 3); step(5); addr = 2;

    // R6, R7, R8: overflow run at full strobe rate
    curReq = "R6";
    fastTick = 1;
    wr(1, 8'h03, 2);
    wr(0, 8'h61, 2);
    while (!mFB) step(1);
    step(1);
    rd(1, v); chk("R6", v, 1);
    chk("R7", irq, 0);
    wr(0, 8'hE1, 1); chk("R7", irq, 1);
    wr(0, 8'hC1, 1); chk("R7", irq, 0);
    wr(1, 8'h01, 1); rd(1, v); chk("R8", v, 0);
    curReq = "R8"; addr = 1;
    while (!mFW) begin
      if (mCnt % 7 == 0) wr(1, 8'h01, 1);
      else step(1);
    end
    step(1);
    rd(1, v); chk("R6", v & 2, 2);
    chk("R7", irq, 1);
    wr(1, 8'h02, 1);
    rd(1, v); chk("R8", v & 2, 0);
    chk("R7", irq, 0);
    step(600);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule